// File: doc/BRIEF.md
# Always-On Match Timer

This block is a low-power counter that keeps running while the rest of the chip is idle. It takes three clock enables: two oscillators and the peripheral clock. A configuration register picks one of them and can pass it through a small prescaler. The result is a system tick. A rate divider thins that tick again, and each divided tick advances a count. When the count climbs to a programmed end value, the block sets a sticky status flag and a second copy of that flag. It also sends a single-cycle event to the interrupt controller.

Software drives the block through a plain memory-mapped register bus. Writes take effect on the clock edge. Reads are combinational from the address. A command register starts and stops the count. Writing 1 to its clear bit returns the count to zero and drops both flags. The clock multiplexer is modelled with enables rather than with gated clocks, so the whole block runs on one clock.

Top module: `aon_match_timer`

## Requirements
- R1: After reset, every register reads 0, the count is 0, both flags are 0 and `match_evt` is low.
- R2: Source selection is held in configuration register 0x00. When bit 25 is 1, `pclk_en` is the source. When bit 25 is 0, bit 0 selects the source: 0 selects `osc0_en` and 1 selects `osc1_en`. An enable that is not selected has no effect on the count.
- R3: Configuration bit 24 turns the prescaler on. Bits 23:20 hold a value V, and the prescaler then emits one system tick for every V+1 source ticks. When bit 24 is 0, every source tick is a system tick, whatever V holds.
- R4: The rate divider register is at 0x74 and holds a value D. While running, the count advances once every D system ticks, and it never steps by more than 1. D = 0 behaves as D = 1.
- R5: The command register is at 0x6C, and bit 0 is the run flag. While bit 0 is 0 the count holds its value.
- R6: When the count steps to the end value held at 0x70, the block does three things on that same edge. It sets bit 0 of status register 0x7C. It sets bit 0 of the copy at 0x04. It raises `match_evt` for exactly one cycle.
- R7: After a match the count stays at the end value and does not wrap. No further `match_evt` pulse follows while the end value is unchanged.
- R8: Writing a 1 to bit 1 of register 0x6C does four things on the same edge. It clears the count. It clears both flags. It restarts the prescaler and divider phases. It loads the run flag from bit 0 of the same write. From a clear, with a source tick every cycle, the match arrives exactly end × (V+1 or 1) × max(D,1) cycles after the write edge.
- R9: Bus writes to the count (0x78), the status (0x7C) and the copy (0x04) are ignored.
- R10: The bits of register 0x00 that the block uses (25, 24, 23:20 and 0) read back as written, and its other bits read 0. The count can be read at 0x78 at any time. An unmapped address reads 0.
- R11: Once set, the status flag stays set until a clear command, even if the timer is stopped or reconfigured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc0_en | input | 1 | Tick enable of oscillator 0 |
| osc1_en | input | 1 | Tick enable of oscillator 1 |
| pclk_en | input | 1 | Tick enable of the peripheral clock |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| match_evt | output | 1 | One-cycle match event to the interrupt controller |

## Verification
The exact arrival time of a match is the hardest thing to observe at the ports. It depends on the phase of two hidden counters, the prescaler and the rate divider, and neither can be read back. The bench therefore always starts a measurement with a single write that both clears and runs the timer, which puts both phases at zero. It then holds the selected source enable high every cycle. With those two conditions, the cycle count to `match_evt` is exactly the product of the end value, the prescale ratio and the divider. A single off-by-one in either counter changes that product.

// File: rtl/aon_tmr_pkg.sv
package aon_tmr_pkg;

    // Register byte offsets
    localparam int unsigned OFS_CFG  = 'h00;
    localparam int unsigned OFS_COPY = 'h04;
    localparam int unsigned OFS_CMD  = 'h6C;
    localparam int unsigned OFS_END  = 'h70;
    localparam int unsigned OFS_RATE = 'h74;
    localparam int unsigned OFS_CNT  = 'h78;
    localparam int unsigned OFS_STAT = 'h7C;

    // Field positions
    localparam int unsigned CFG_OSC_BIT  = 0;
    localparam int unsigned CFG_PRE_LSB  = 20;
    localparam int unsigned CFG_PRE_EN   = 24;
    localparam int unsigned CFG_PCLK_BIT = 25;
    localparam int unsigned CMD_RUN_BIT  = 0;
    localparam int unsigned CMD_CLR_BIT  = 1;

    localparam int unsigned PRE_W = 4;
    localparam int unsigned BUS_W = 32;

    typedef struct packed {
        logic             pclk_sel;
        logic             pre_en;
        logic [PRE_W-1:0] pre_val;
        logic             osc_sel;
    } clk_cfg_t;

endpackage

// File: rtl/aon_clk_sel.sv
module aon_clk_sel
    import aon_tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  clk_cfg_t cfg,
    input  logic     osc0_en,
    input  logic     osc1_en,
    input  logic     pclk_en,
    output logic     sys_tick
);

    typedef struct packed {
        logic [PRE_W-1:0] ph;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    src_tick;

    always_comb begin
        st_d     = st_q;
        sys_tick = 1'b0;
        src_tick = cfg.pclk_sel ? pclk_en : (cfg.osc_sel ? osc1_en : osc0_en);
        if (clr) begin
            st_d.ph = '0;
        end else if (src_tick) begin
            if (!cfg.pre_en) begin
                sys_tick = 1'b1;
            end else if (st_q.ph == cfg.pre_val) begin
                st_d.ph  = '0;
                sys_tick = 1'b1;
            end else begin
                st_d.ph = st_q.ph + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/aon_rate_div.sv
module aon_rate_div #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             sys_tick,
    input  logic [DIV_W-1:0] div_val,
    output logic             cnt_tick
);

    typedef struct packed {
        logic [DIV_W-1:0] ph;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [DIV_W-1:0] last_ph;

    always_comb begin
        st_d     = st_q;
        cnt_tick = 1'b0;
        last_ph  = (div_val == '0) ? '0 : div_val - DIV_W'(1);
        if (clr) begin
            st_d.ph = '0;
        end else if (run && sys_tick) begin
            if (st_q.ph >= last_ph) begin
                st_d.ph  = '0;
                cnt_tick = 1'b1;
            end else begin
                st_d.ph = st_q.ph + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/aon_tmr_core.sv
module aon_tmr_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] end_val,
    output logic [CNT_W-1:0] cnt,
    output logic             status,
    output logic             copy,
    output logic             evt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             status;
        logic             copy;
        logic             evt;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        cnt_inc  = st_q.cnt + CNT_W'(1);
        if (clr) begin
            st_d.cnt    = '0;
            st_d.status = 1'b0;
            st_d.copy   = 1'b0;
        end else if (run && cnt_tick && (st_q.cnt != end_val)) begin
            st_d.cnt = cnt_inc;
            if (cnt_inc == end_val) begin
                st_d.status = 1'b1;
                st_d.copy   = 1'b1;
                st_d.evt    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign status = st_q.status;
    assign copy   = st_q.copy;
    assign evt    = st_q.evt;

endmodule

// File: rtl/aon_match_timer.sv
module aon_match_timer
    import aon_tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc0_en,
    input  logic              osc1_en,
    input  logic              pclk_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              match_evt
);

    typedef struct packed {
        clk_cfg_t         cfg;
        logic [CNT_W-1:0] end_v;
        logic [DIV_W-1:0] div_v;
        logic             run;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic             clr_cmd;
    logic             run_now;
    logic             sys_tick;
    logic             cnt_tick;
    logic [CNT_W-1:0] cur_cnt;
    logic             cur_stat;
    logic             cur_copy;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
        return a == ADDR_W'(ofs);
    endfunction

    // Register writes
    always_comb begin
        regs_d  = regs_q;
        clr_cmd = 1'b0;
        if (bus_wr) begin
            if (hit(bus_addr, OFS_CFG)) begin
                regs_d.cfg.pclk_sel = bus_wdata[CFG_PCLK_BIT];
                regs_d.cfg.pre_en   = bus_wdata[CFG_PRE_EN];
                regs_d.cfg.pre_val  = bus_wdata[CFG_PRE_LSB +: PRE_W];
                regs_d.cfg.osc_sel  = bus_wdata[CFG_OSC_BIT];
            end
            if (hit(bus_addr, OFS_CMD)) begin
                regs_d.run = bus_wdata[CMD_RUN_BIT];
                clr_cmd    = bus_wdata[CMD_CLR_BIT];
            end
            if (hit(bus_addr, OFS_END))  regs_d.end_v = bus_wdata[CNT_W-1:0];
            if (hit(bus_addr, OFS_RATE)) regs_d.div_v = bus_wdata[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign run_now = regs_q.run;

    // Register reads
    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, OFS_CFG)) begin
            bus_rdata[CFG_PCLK_BIT]             = regs_q.cfg.pclk_sel;
            bus_rdata[CFG_PRE_EN]               = regs_q.cfg.pre_en;
            bus_rdata[CFG_PRE_LSB +: PRE_W]     = regs_q.cfg.pre_val;
            bus_rdata[CFG_OSC_BIT]              = regs_q.cfg.osc_sel;
        end
        if (hit(bus_addr, OFS_COPY)) bus_rdata[0] = cur_copy;
        if (hit(bus_addr, OFS_CMD))  bus_rdata[CMD_RUN_BIT] = regs_q.run;
        if (hit(bus_addr, OFS_END))  bus_rdata[CNT_W-1:0] = regs_q.end_v;
        if (hit(bus_addr, OFS_RATE)) bus_rdata[DIV_W-1:0] = regs_q.div_v;
        if (hit(bus_addr, OFS_CNT))  bus_rdata[CNT_W-1:0] = cur_cnt;
        if (hit(bus_addr, OFS_STAT)) bus_rdata[0] = cur_stat;
    end

    aon_clk_sel u_clk_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_cmd),
        .cfg      (regs_q.cfg),
        .osc0_en  (osc0_en),
        .osc1_en  (osc1_en),
        .pclk_en  (pclk_en),
        .sys_tick (sys_tick)
    );

    aon_rate_div #(.DIV_W(DIV_W)) u_rate_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_cmd),
        .run      (run_now),
        .sys_tick (sys_tick),
        .div_val  (regs_q.div_v),
        .cnt_tick (cnt_tick)
    );

    aon_tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_cmd),
        .run      (run_now),
        .cnt_tick (cnt_tick),
        .end_val  (regs_q.end_v),
        .cnt      (cur_cnt),
        .status   (cur_stat),
        .copy     (cur_copy),
        .evt      (match_evt)
    );

endmodule

// File: rtl/aon_match_timer_chk.sv
module aon_match_timer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic             status,
    input logic             evt
);

    p_evt_sets_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> status);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    p_status_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr) |=> status);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !status));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

    p_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt));

endmodule

bind aon_match_timer aon_match_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_cmd),
    .run    (run_now),
    .cnt    (cur_cnt),
    .status (cur_stat),
    .evt    (match_evt)
);

// File: tb/sim_aon_match_timer.sv
module sim_aon_match_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc0_en = 1'b0, osc1_en = 1'b0, pclk_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        match_evt;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    aon_match_timer u0 (
        .clk(clk), .rst_n(rst_n), .osc0_en(osc0_en), .osc1_en(osc1_en),
        .pclk_en(pclk_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .match_evt(match_evt)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // Counts edges after the last write until match_evt is seen; -1 on timeout
    task automatic wait_match(input int lim, output int n);
        n = 0;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (match_evt) break;
            if (n > lim) begin n = -1; break; end
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd('h00, v); check("R1 cfg", v, 0);
        rd('h78, v); check("R1 count", v, 0);
        rd('h7C, v); check("R1 status", v, 0);
        rd('h04, v); check("R1 copy", v, 0);
        check("R1 evt", match_evt, 0);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        wr('h00, 32'hFFFF_FFFF);
        rd('h00, v); check("R10 cfg unused bits zero", v, 32'h03F0_0001);
        wr('h00, 32'h0150_0000);
        rd('h00, v); check("R10 cfg readback", v, 32'h0150_0000);
        rd('h40, v); check("R10 unmapped", v, 0);
    endtask

    task automatic t_basic;
        logic [31:0] v; int n;
        pclk_en = 1'b1;
        wr('h00, 32'h0200_0000);
        wr('h74, 1);
        wr('h70, 5);
        wr('h6C, 3);
        wait_match(100, n);
        check("R6 match time", n, 5);
        rd('h7C, v); check("R6 status", v, 1);
        rd('h04, v); check("R6 copy", v, 1);
        check("R7 evt one cycle", match_evt, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (match_evt) check("R7 no second pulse", 1, 0);
        end
        rd('h78, v); check("R7 count holds", v, 5);
    endtask

    task automatic t_ignored;
        logic [31:0] v;
        wr('h78, 55); wr('h7C, 0); wr('h04, 0);
        rd('h78, v); check("R9 count write", v, 5);
        rd('h7C, v); check("R9 status write", v, 1);
        rd('h04, v); check("R9 copy write", v, 1);
    endtask

    task automatic t_sticky;
        logic [31:0] v;
        wr('h6C, 0);
        wr('h70, 40);
        wr('h00, 32'h0100_0000);
        idle(5);
        rd('h7C, v); check("R11 status sticky", v, 1);
        wr('h00, 32'h0200_0000);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr('h6C, 2);
        rd('h78, v); check("R8 count cleared", v, 0);
        rd('h7C, v); check("R8 status cleared", v, 0);
        rd('h04, v); check("R8 copy cleared", v, 0);
        rd('h6C, v); check("R8 run from write", v, 0);
        idle(6);
        rd('h78, v); check("R5 stopped holds", v, 0);
    endtask

    task automatic t_stop;
        logic [31:0] a, b;
        wr('h70, 1000);
        wr('h6C, 3);
        idle(8);
        wr('h6C, 0);
        rd('h78, a);
        idle(10);
        rd('h78, b);
        check("R5 count frozen", b, a);
        check("R5 count advanced before stop", (a > 0) ? 1 : 0, 1);
    endtask

    task automatic t_div;
        int n;
        wr('h74, 3); wr('h70, 4); wr('h6C, 3);
        wait_match(200, n); check("R4 divide by 3", n, 12);
        wr('h74, 0); wr('h6C, 3);
        wait_match(200, n); check("R4 divide 0 as 1", n, 4);
    endtask

    task automatic t_pre;
        int n;
        wr('h00, 32'h0320_0000);
        wr('h74, 2); wr('h70, 3); wr('h6C, 3);
        wait_match(500, n); check("R3 prescale 3 div 2", n, 18);
        wr('h00, 32'h0220_0000);
        wr('h74, 1); wr('h6C, 3);
        wait_match(500, n); check("R3 prescaler bypass", n, 3);
    endtask

    task automatic t_src;
        logic [31:0] v; int n;
        pclk_en = 1'b0; osc1_en = 1'b1; osc0_en = 1'b0;
        wr('h00, 32'h0000_0000); wr('h70, 6); wr('h6C, 3);
        idle(20);
        rd('h78, v); check("R2 osc0 idle source", v, 0);
        wr('h00, 32'h0200_0001); wr('h6C, 3);
        idle(20);
        rd('h78, v); check("R2 pclk selected idle", v, 0);
        wr('h00, 32'h0000_0001); wr('h6C, 3);
        wait_match(100, n); check("R2 osc1 selected", n, 6);
    endtask

    initial begin
        idle(3);
        #1 rst_n = 1'b1;
        t_reset();
        t_readback();
        t_basic();
        t_ignored();
        t_sticky();
        t_clear();
        t_stop();
        t_div();
        t_pre();
        t_src();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule